// File: doc/BRIEF.md
# Multi-Rail Power Sequencer

This block turns on and off a group of supply rails for a set of programmable devices. Software drives it through a small 8-bit register port. A single enable bit starts a staged bring-up. The rails switch on one at a time, from the lowest index upward. Each later rail waits for the power-good flag of the rail before it. A stage whose power-good fails to arrive within a per-stage cycle budget ends the bring-up, records which stage failed and powers everything back down.

Clearing the enable tears the rails down in the reverse order, one rail per cycle. The block then holds off for a fixed discharge period before it accepts a new enable. This hold-off stops quick on/off toggling from leaving the regulators partly charged with the sequencer waiting on flags that never arrive.

An alarm input is debounced by a stability filter in revision 3 and later. Once accepted, it forces a shutdown. Aggregate power is good only when all four rail flags are high and the filtered alarm is low. Fault causes stay latched in a fail register until software reads that register or a new bring-up starts.

Top module: `pwr_rail_sequencer`

## Requirements
- R1: After reset all rail enables are low, the control, status and fail registers read 0, and the identity register (address 0) reads the VERSION parameter (3 by default).
- R2: Rail enables always form a contiguous mask from bit 0 upward. Rail k+1 turns on only after power-good k has been seen high; bring-up ends in the on state with all four rails enabled.
- R3: If the power-good of the rail being brought up stays low for STEP_TIMEOUT cycles, fail bit k (k = that rail's index) is set, the control enable bit clears and all rails switch off.
- R4: On shutdown the rails switch off from the highest index downward, one rail per clock cycle.
- R5: After the last rail switches off, writes of 1 to the enable are ignored for DISCHARGE cycles; the control register keeps reading 0 and no rail turns on.
- R6: The status register (address 2) holds the registered power-good inputs in bits 3:0 and the filtered alarm in bit 4. The pwr_good output is high exactly when status equals 0x0F.
- R7: A filtered alarm during bring-up or in the on state sets fail bit 4, clears the enable and shuts all rails down.
- R8: A rail power-good dropping while in the on state sets fail bit 5 and shuts all rails down.
- R9: Fail bits are sticky. A read of the fail register (address 3) returns them and clears them, and an accepted enable also clears them.
- R10: With VERSION of 3 or more, an alarm input high for fewer than ALARM_FILT consecutive cycles is ignored, and one held high for longer is accepted.
- R11: The control register (address 1) bit 0 is the enable and reads back its current value. A write with any of bits 7:1 set is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register select: 0 identity, 1 control, 2 status, 3 fail |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe; reg_rdata is valid the following cycle |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pgood_in | input | 4 | Per-rail power-good flags |
| alarm_in | input | 1 | Overcurrent/overtemperature alarm |
| rail_en | output | 4 | Per-rail enables |
| pwr_good | output | 1 | All rails good and no alarm |

## Verification
Bring-up is run under several patterns of per-rail power-good delays. These show that the stage ordering follows the flags and not a fixed schedule. A sweep kills each rail in turn, and the fail bit that results must name exactly that rail; this separates a correct stage index from an off-by-one. Alarm pulses just below the filter length and held alarms tell the debounce apart from a plain pass-through. An enable written in the first cycle after teardown, and again after the discharge period, separates the hold-off from an unconditional accept.

// File: rtl/psq_pkg.sv
package psq_pkg;
  typedef enum logic [2:0] {
    ST_OFF   = 3'd0,
    ST_RAMP  = 3'd1,
    ST_ON    = 3'd2,
    ST_DOWN  = 3'd3,
    ST_DISCH = 3'd4
  } seq_state_e;

  localparam logic [1:0] ADDR_ID   = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_FAIL = 2'd3;
endpackage

// File: rtl/psq_alarm_filter.sv
module psq_alarm_filter #(
  parameter int FILT_LEN = 4,
  parameter bit USE_FILT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  logic raw_q;
  logic filt_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) raw_q <= 1'b0;
    else        raw_q <= raw;

  generate
    if (USE_FILT) begin : g_filter
      localparam int CW = $clog2(FILT_LEN + 1);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt    <= '0;
          filt_q <= 1'b0;
        end else if (raw_q == filt_q) begin
          cnt <= '0;
        end else if (cnt == CW'(FILT_LEN - 1)) begin
          filt_q <= raw_q;
          cnt    <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) filt_q <= 1'b0;
        else        filt_q <= raw_q;
    end
  endgenerate

  assign filt = filt_q;
endmodule

// File: rtl/psq_sequencer.sv
module psq_sequencer
  import psq_pkg::*;
#(
  parameter int NR        = 4,
  parameter int STEP_TO   = 24,
  parameter int DISCHARGE = 40
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_req,
  input  logic [NR-1:0] pg,
  input  logic          alarm,
  output logic [NR-1:0] rail_en,
  output seq_state_e    st,
  output logic          start,
  output logic          ctrl_clr,
  output logic [NR+1:0] fail_set
);
  localparam int TMAX = (STEP_TO > DISCHARGE) ? STEP_TO : DISCHARGE;
  localparam int TW   = $clog2(TMAX + 1);
  localparam int IW   = (NR > 1) ? $clog2(NR) : 1;

  seq_state_e    st_n;
  logic [NR-1:0] mask, mask_n;
  logic [IW-1:0] idx, idx_n;
  logic [TW-1:0] tmr, tmr_n;

  always_comb begin
    st_n     = st;
    mask_n   = mask;
    idx_n    = idx;
    tmr_n    = tmr;
    start    = 1'b0;
    ctrl_clr = 1'b0;
    fail_set = '0;
    case (st)
      ST_OFF: if (en_req) begin
        st_n   = ST_RAMP;
        mask_n = NR'(1);
        idx_n  = '0;
        tmr_n  = '0;
        start  = 1'b1;
      end
      ST_RAMP: begin
        if (alarm) begin
          fail_set[NR] = 1'b1;
          ctrl_clr     = 1'b1;
          st_n         = ST_DOWN;
        end else if (!en_req) begin
          st_n = ST_DOWN;
        end else if (pg[idx]) begin
          tmr_n = '0;
          if (idx == IW'(NR - 1)) st_n = ST_ON;
          else begin
            idx_n  = idx + 1'b1;
            mask_n = {mask[NR-2:0], 1'b1};
          end
        end else if (tmr == TW'(STEP_TO - 1)) begin
          fail_set[idx] = 1'b1;
          ctrl_clr      = 1'b1;
          st_n          = ST_DOWN;
        end else begin
          tmr_n = tmr + 1'b1;
        end
      end
      ST_ON: begin
        if (alarm) begin
          fail_set[NR] = 1'b1;
          ctrl_clr     = 1'b1;
          st_n         = ST_DOWN;
        end else if (!en_req) begin
          st_n = ST_DOWN;
        end else if (pg != '1) begin
          fail_set[NR+1] = 1'b1;
          ctrl_clr       = 1'b1;
          st_n           = ST_DOWN;
        end
      end
      ST_DOWN: begin
        if (mask == '0) begin
          st_n  = ST_DISCH;
          tmr_n = '0;
        end else begin
          mask_n = mask >> 1;
        end
      end
      ST_DISCH: begin
        if (tmr == TW'(DISCHARGE - 1)) st_n = ST_OFF;
        else                           tmr_n = tmr + 1'b1;
      end
      default: st_n = ST_OFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_OFF;
      mask <= '0;
      idx  <= '0;
      tmr  <= '0;
    end else begin
      st   <= st_n;
      mask <= mask_n;
      idx  <= idx_n;
      tmr  <= tmr_n;
    end
  end

  assign rail_en = mask;
endmodule

// File: rtl/psq_regs.sv
module psq_regs
  import psq_pkg::*;
#(
  parameter int NR      = 4,
  parameter int VERSION = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    addr,
  input  logic          wr,
  input  logic          rd,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  input  logic          seq_idle,
  input  logic          start,
  input  logic          ctrl_clr,
  input  logic [NR+1:0] fail_set,
  input  logic [7:0]    status,
  output logic          en_req,
  output logic [NR+1:0] fail_q
);
  logic ctrl_q;
  logic wr_ctrl;

  assign wr_ctrl = wr && (addr == ADDR_CTRL) && (wdata[7:1] == 7'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= 1'b0;
    else if (ctrl_clr) ctrl_q <= 1'b0;
    else if (wr_ctrl) begin
      if (!wdata[0])     ctrl_q <= 1'b0;
      else if (seq_idle) ctrl_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         fail_q <= '0;
    else if (start)                     fail_q <= '0;
    else if (rd && addr == ADDR_FAIL)   fail_q <= fail_set;
    else                                fail_q <= fail_q | fail_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd) begin
      case (addr)
        ADDR_ID:   rdata <= 8'(VERSION);
        ADDR_CTRL: rdata <= {7'd0, ctrl_q};
        ADDR_STAT: rdata <= status;
        default:   rdata <= 8'(fail_q);
      endcase
    end
  end

  assign en_req = ctrl_q;
endmodule

// File: rtl/pwr_rail_sequencer.sv
module pwr_rail_sequencer
  import psq_pkg::*;
#(
  parameter int NR         = 4,
  parameter int STEP_TO    = 24,
  parameter int DISCHARGE  = 40,
  parameter int ALARM_FILT = 4,
  parameter int VERSION    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_addr,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  input  logic [NR-1:0] pgood_in,
  input  logic          alarm_in,
  output logic [NR-1:0] rail_en,
  output logic          pwr_good
);
  logic [NR-1:0] pg_q;
  logic          alarm_f;
  logic          en_req;
  logic          seq_start;
  logic          ctrl_clr;
  logic [NR+1:0] fail_set;
  logic [NR+1:0] fail_vec;
  logic [7:0]    status;
  seq_state_e    seq_st;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pg_q <= '0;
    else        pg_q <= pgood_in;

  assign status   = 8'({alarm_f, pg_q});
  assign pwr_good = (status == 8'({1'b0, {NR{1'b1}}}));

  psq_alarm_filter #(
    .FILT_LEN (ALARM_FILT),
    .USE_FILT (VERSION >= 3)
  ) u_filt (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (alarm_in),
    .filt (alarm_f)
  );

  psq_sequencer #(
    .NR       (NR),
    .STEP_TO  (STEP_TO),
    .DISCHARGE(DISCHARGE)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_req  (en_req),
    .pg      (pg_q),
    .alarm   (alarm_f),
    .rail_en (rail_en),
    .st      (seq_st),
    .start   (seq_start),
    .ctrl_clr(ctrl_clr),
    .fail_set(fail_set)
  );

  psq_regs #(
    .NR     (NR),
    .VERSION(VERSION)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (reg_addr),
    .wr      (reg_wr),
    .rd      (reg_rd),
    .wdata   (reg_wdata),
    .rdata   (reg_rdata),
    .seq_idle(seq_st == ST_OFF),
    .start   (seq_start),
    .ctrl_clr(ctrl_clr),
    .fail_set(fail_set),
    .status  (status),
    .en_req  (en_req),
    .fail_q  (fail_vec)
  );
endmodule

// File: rtl/psq_checker.sv
module psq_checker
  import psq_pkg::*;
#(
  parameter int NR = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [NR-1:0] rail_en,
  input logic [NR-1:0] pgood_in,
  input logic          pwr_good,
  input logic          reg_rd,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_rdata,
  input seq_state_e    seq_st,
  input logic [NR+1:0] fail_vec,
  input logic          seq_start
);
  // R2: enables are always a low-order contiguous mask
  assert_contig_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((rail_en & (rail_en + 1'b1)) == '0));

  genvar k;
  generate
    for (k = 0; k < NR - 1; k++) begin : g_pair
      // R2: a rail rises only after the previous rail reported good
      assert_step_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rail_en[k+1]) |-> $past(pgood_in[k], 2));
      // R4: a rail falls only once every higher rail is already off
      assert_reverse_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rail_en[k]) |-> !rail_en[k+1]);
    end
  endgenerate

  // R5: during discharge no rail is driven and the only exit is to idle
  assert_discharge_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == ST_DISCH) |-> (rail_en == '0));
  assert_discharge_exit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_st == ST_DISCH) |=> (seq_st == ST_DISCH || seq_st == ST_OFF));

  // R6: a status read returns 0x0F exactly when aggregate power was good
  assert_status_good_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == ADDR_STAT) |=> ((reg_rdata == 8'h0F) == $past(pwr_good)));

  // R9: latched fail bits survive unless a fail read or a new bring-up clears them
  assert_fail_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(reg_rd && reg_addr == ADDR_FAIL) && !seq_start) |=> ((fail_vec & $past(fail_vec)) == $past(fail_vec)));
endmodule

bind pwr_rail_sequencer psq_checker #(.NR(NR)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .rail_en  (rail_en),
  .pgood_in (pgood_in),
  .pwr_good (pwr_good),
  .reg_rd   (reg_rd),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .seq_st   (seq_st),
  .fail_vec (fail_vec),
  .seq_start(seq_start)
);

// File: tb/pwr_rail_sequencer_tb_top.sv
module pwr_rail_sequencer_tb_top;
  localparam int NR = 4, STEP_TO = 24, DISCH = 40, FILT = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] reg_addr = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] pgood = '0;
  logic       alarm = 1'b0;
  logic [3:0] rail_en;
  logic       pwr_good;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  int dly[4];
  logic [3:0] dead = '0, lose = '0;
  int cnt[4];
  logic [3:0] prev_en = '0;

  always #10 clk = ~clk;

  pwr_rail_sequencer #(.NR(NR), .STEP_TO(STEP_TO), .DISCHARGE(DISCH),
                       .ALARM_FILT(FILT), .VERSION(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pgood_in(pgood), .alarm_in(alarm), .rail_en(rail_en), .pwr_good(pwr_good));

  // regulator model: good flag follows enable after a per-rail delay
  always @(posedge clk) begin
    for (int k = 0; k < 4; k++) begin
      if (!rail_en[k]) begin cnt[k] <= 0; pgood[k] <= 1'b0; end
      else if (dead[k] || lose[k]) pgood[k] <= 1'b0;
      else if (cnt[k] >= dly[k]) pgood[k] <= 1'b1;
      else cnt[k] <= cnt[k] + 1;
    end
  end

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  // R2 / R4: every change of the enable mask steps by exactly one rail
  always @(negedge clk) begin
    if (rst_n && rail_en !== prev_en) begin
      if (rail_en > prev_en) check("R2 ramp step", 8'(rail_en), 8'(((prev_en << 1) | 4'h1) & 4'hF));
      else                   check("R4 reverse step", 8'(rail_en), 8'(prev_en >> 1));
    end
    prev_en <= rail_en;
  end

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_rd = 1'b1;
    @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_good();
    for (int i = 0; i < 300 && !pwr_good; i++) @(negedge clk);
  endtask

  task automatic shut_and_drain();
    wr(2'd1, 8'h00);
    for (int i = 0; i < 20 && rail_en != 0; i++) @(negedge clk);
    idle(DISCH + 10);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x00 expected 0x01");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] v;
    for (int k = 0; k < 4; k++) dly[k] = 2;
    idle(3);
    rst_n = 1'b1;
    idle(2);
    check("R1 rails off", 8'(rail_en), 8'h00);
    rd(2'd0, v); check("R1 version", v, 8'h03);
    rd(2'd1, v); check("R1 R11 ctrl reset", v, 8'h00);
    rd(2'd2, v); check("R1 R6 status reset", v, 8'h00);
    rd(2'd3, v); check("R1 fail reset", v, 8'h00);

    // R11: write with reserved bits set is ignored
    wr(2'd1, 8'h03); rd(2'd1, v); check("R11 reserved write ignored", v, 8'h00);
    check("R11 no ramp", 8'(rail_en), 8'h00);

    // R2 / R6 / R4 / R5 over several power-good delay patterns
    for (int p = 0; p < 4; p++) begin
      for (int k = 0; k < 4; k++) dly[k] = ((p * 3 + k * (p + 1)) % 6) + 1;
      wr(2'd1, 8'h01);
      rd(2'd1, v); check("R11 ctrl readback", v, 8'h01);
      wait_good();
      check("R2 all rails on", 8'(rail_en), 8'h0F);
      check("R6 pwr_good", 8'(pwr_good), 8'h01);
      rd(2'd2, v); check("R6 status all good", v, 8'h0F);
      rd(2'd3, v); check("R9 no fail", v, 8'h00);
      wr(2'd1, 8'h00);
      for (int i = 0; i < 20 && rail_en != 0; i++) @(negedge clk);
      check("R4 all rails off", 8'(rail_en), 8'h00);
      wr(2'd1, 8'h01);
      rd(2'd1, v); check("R5 enable during discharge", v, 8'h00);
      idle(5);
      check("R5 rails stay off", 8'(rail_en), 8'h00);
      idle(DISCH + 10);
    end

    // R3: sweep the dead rail
    for (int k = 0; k < 4; k++) dly[k] = 3;
    for (int k = 0; k < 4; k++) begin
      dead = 4'(1 << k);
      wr(2'd1, 8'h01);
      idle(4 * (STEP_TO + 10));
      check("R3 rails off after timeout", 8'(rail_en), 8'h00);
      rd(2'd1, v); check("R3 enable cleared", v, 8'h00);
      if (k != 3) begin
        rd(2'd3, v); check("R3 fail names rail", v, 8'(1 << k));
        rd(2'd3, v); check("R9 clear on read", v, 8'h00);
      end else begin
        rd(2'd2, v); check("R6 status rails down", v, 8'h00);
      end
      idle(DISCH + 10);
    end
    dead = '0;

    // R9: latched bit 3 cleared by accepted enable
    wr(2'd1, 8'h01);
    wait_good();
    rd(2'd3, v); check("R9 clear on enable", v, 8'h00);

    // R10: short alarm glitch ignored
    alarm = 1'b1; idle(FILT - 1); alarm = 1'b0;
    idle(10);
    check("R10 glitch no effect", 8'(pwr_good), 8'h01);
    rd(2'd2, v); check("R10 status after glitch", v, 8'h0F);
    rd(2'd3, v); check("R10 no fail after glitch", v, 8'h00);

    // R7 / R10: held alarm accepted
    alarm = 1'b1; idle(FILT + 4);
    rd(2'd2, v); check("R10 R6 alarm bit", v & 8'h10, 8'h10);
    idle(10);
    check("R7 rails off", 8'(rail_en), 8'h00);
    rd(2'd3, v); check("R7 alarm fail bit", v, 8'h10);
    rd(2'd1, v); check("R7 enable cleared", v, 8'h00);
    alarm = 1'b0;
    idle(DISCH + 20);

    // R7: alarm during bring-up
    for (int k = 0; k < 4; k++) dly[k] = 8;
    wr(2'd1, 8'h01);
    idle(3);
    alarm = 1'b1; idle(FILT + 6); alarm = 1'b0;
    idle(10);
    check("R7 ramp abort rails off", 8'(rail_en), 8'h00);
    rd(2'd3, v); check("R7 ramp alarm fail", v, 8'h10);
    idle(DISCH + 20);

    // R8: rail loss while on
    for (int k = 0; k < 4; k++) dly[k] = 2;
    wr(2'd1, 8'h01);
    wait_good();
    lose = 4'b0100;
    idle(12);
    check("R8 rails off", 8'(rail_en), 8'h00);
    rd(2'd3, v); check("R8 loss fail bit", v, 8'h20);
    lose = '0;
    shut_and_drain();

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule